// File: doc/BRIEF.md
# Data Path Transfer Counter and Timeout Supervisor

This block tracks one data transfer on a card interface. It runs a small state machine through receive, send, acknowledgment wait and card-busy phases. It also keeps three down-counters: a byte counter, a data timeout timer and an acknowledgment timeout timer. A start strobe arms a transfer. The length and the two timeout periods come from configuration inputs and are captured when they are needed.

The rest of the data path supplies abstract event strobes: byte transferred, acknowledgment received and card busy. A card-clock enable strobe paces both timers. The block reports the current phase and the bytes still to go. It gives single-cycle pulses for a clean finish, a data timeout and an acknowledgment timeout.

A timeout always ends the transfer at once, and that transfer never reports a clean finish.

Top module: `dpath_timer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `state` is Idle (code 0), `count_left` is 0, and `data_end`, `data_tmo` and `ack_tmo` are low.
- R2: A `start` strobe in Idle moves the block on the next edge to Wait_R (code 2) if `dir_rx` is 1, or to Wait_S (code 1) if `dir_rx` is 0, and loads `count_left` with `cfg_len`. A `start` strobe outside Idle has no effect on `state` or `count_left`.
- R3: In Wait_R or Wait_S, `byte_done` lowers a nonzero `count_left` by exactly one on the next edge. In every other state `byte_done` leaves `count_left` unchanged.
- R4: In Wait_R, at the first edge where `count_left` is already 0, the block returns to Idle and pulses `data_end` for one cycle. A length of 0 therefore finishes one edge after entry.
- R5: In Wait_S, at the first edge where `count_left` is 0, the block moves to Wait_Ack (code 3). From there `ack_rx` moves it to Busy (code 4). In Busy, an edge with `card_busy` low returns it to Idle with a one-cycle `data_end` pulse.
- R6: The data timer loads `cfg_dtmo` on leaving Idle and again on entering Busy. It counts only at edges where `ck_en` is high while the state is Wait_R or Busy. On such an edge with the timer already 0, `data_tmo` pulses and the state returns to Idle. A period P therefore times out on the (P+1)th enabled edge, and 0 times out on the first.
- R7: The acknowledgment timer loads `cfg_atmo` on entering Wait_Ack. It counts only at `ck_en` edges in Wait_Ack. An enabled edge that finds it at 0 pulses `ack_tmo` and returns the state to Idle, so a period A times out on the (A+1)th enabled edge.
- R8: A timeout takes precedence over completion, `ack_rx` and busy release in the same cycle. `data_end` never pulses for a transfer that timed out.
- R9: `data_end`, `data_tmo` and `ack_tmo` are mutually exclusive single-cycle pulses, raised only with `state` already Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_dtmo | input | DTMO_W | Data timeout period in card clock enables |
| cfg_atmo | input | ATMO_W | Acknowledgment timeout period in card clock enables |
| ck_en | input | 1 | Card clock enable strobe pacing both timers |
| start | input | 1 | Begin a transfer (only acted on in Idle) |
| dir_rx | input | 1 | 1 = receive, 0 = send, sampled with start |
| byte_done | input | 1 | One byte moved on the card lines |
| ack_rx | input | 1 | Card acknowledgment received |
| card_busy | input | 1 | Card signals busy |
| state | output | 3 | Phase code: 0 Idle, 1 Wait_S, 2 Wait_R, 3 Wait_Ack, 4 Busy |
| count_left | output | LEN_W | Bytes still to transfer |
| data_end | output | 1 | Clean finish pulse |
| data_tmo | output | 1 | Data timeout pulse |
| ack_tmo | output | 1 | Acknowledgment timeout pulse |

## Verification
An off-by-one in a timer shows as `data_tmo` or `ack_tmo` arriving one enabled edge early or late. Sweeping the period from 0 upward, and checking the state after every single enable, pins that error to the exact edge. A counter that is armed in the wrong state shows as a timeout during Wait_S or Wait_Ack, or as a reaction to `ck_en`-low cycles. A byte counter that steps wrongly shows in `count_left` right after each strobe, and in `data_end` appearing one edge away from where the length predicts. Priority faults show as `data_end` or a Busy state on the edge where a timeout was due.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_WS   = 3'd1,
      S_WR   = 3'd2,
      S_WACK = 3'd3,
      S_BUSY = 3'd4
   } dp_state_e;

   localparam int unsigned STATE_W = 3;

endpackage

// File: rtl/dpc_downcnt.sv
module dpc_downcnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 1) begin : g_bad_width
         $error("dpc_downcnt: W must be at least 1");
      end
   endgenerate

   assign zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec && !zero) begin
         cnt <= cnt - ONE;
      end
   end

   // R3 / R6 / R7: one step per accepted decrement
   a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

   // R6 / R7: an idle counter keeps its value
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !load) |=> $stable(cnt));

endmodule

// File: rtl/dpc_fsm.sv
module dpc_fsm
   import dpc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      dir_rx,
   input  logic      byte_done,
   input  logic      ack_rx,
   input  logic      card_busy,
   input  logic      ck_en,
   input  logic      len_zero,
   input  logic      dt_zero,
   input  logic      at_zero,
   output dp_state_e st,
   output logic      len_load,
   output logic      len_dec,
   output logic      dt_load,
   output logic      dt_dec,
   output logic      at_load,
   output logic      at_dec,
   output logic      data_end,
   output logic      data_tmo,
   output logic      ack_tmo
);

   dp_state_e st_nxt;
   logic      end_nxt;
   logic      dto_nxt;
   logic      ato_nxt;

   always_comb begin
      st_nxt   = st;
      end_nxt  = 1'b0;
      dto_nxt  = 1'b0;
      ato_nxt  = 1'b0;
      len_load = 1'b0;
      len_dec  = 1'b0;
      dt_load  = 1'b0;
      dt_dec   = 1'b0;
      at_load  = 1'b0;
      at_dec   = 1'b0;
      unique case (st)
         S_IDLE: begin
            if (start) begin
               len_load = 1'b1;
               dt_load  = 1'b1;
               st_nxt   = dir_rx ? S_WR : S_WS;
            end
         end
         S_WR: begin
            if (ck_en && dt_zero) begin
               dto_nxt = 1'b1;
               st_nxt  = S_IDLE;
            end else begin
               dt_dec = ck_en;
               if (len_zero) begin
                  end_nxt = 1'b1;
                  st_nxt  = S_IDLE;
               end else begin
                  len_dec = byte_done;
               end
            end
         end
         S_WS: begin
            if (len_zero) begin
               at_load = 1'b1;
               st_nxt  = S_WACK;
            end else begin
               len_dec = byte_done;
            end
         end
         S_WACK: begin
            if (ck_en && at_zero) begin
               ato_nxt = 1'b1;
               st_nxt  = S_IDLE;
            end else begin
               at_dec = ck_en;
               if (ack_rx) begin
                  dt_load = 1'b1;
                  st_nxt  = S_BUSY;
               end
            end
         end
         S_BUSY: begin
            if (ck_en && dt_zero) begin
               dto_nxt = 1'b1;
               st_nxt  = S_IDLE;
            end else begin
               dt_dec = ck_en;
               if (!card_busy) begin
                  end_nxt = 1'b1;
                  st_nxt  = S_IDLE;
               end
            end
         end
         default: st_nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         data_end <= 1'b0;
         data_tmo <= 1'b0;
         ack_tmo  <= 1'b0;
      end else begin
         st       <= st_nxt;
         data_end <= end_nxt;
         data_tmo <= dto_nxt;
         ack_tmo  <= ato_nxt;
      end
   end

   // R2: start in Idle always leaves Idle for a wait state
   a_r2_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && start) |=> (st == S_WR || st == S_WS));

   // R9: at most one result pulse, and only once back in Idle
   a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({data_end, data_tmo, ack_tmo}));
   a_r9_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (data_end || data_tmo || ack_tmo) |-> (st == S_IDLE));

   // R6: a data timeout only comes out of Wait_R or Busy
   a_r6_dto_origin: assert property (@(posedge clk) disable iff (!rst_n)
      data_tmo |-> ($past(st) == S_WR || $past(st) == S_BUSY));

   // R7: an ack timeout only comes out of Wait_Ack
   a_r7_ato_origin: assert property (@(posedge clk) disable iff (!rst_n)
      ack_tmo |-> ($past(st) == S_WACK));

   // R5: Busy is held while the card stays busy and no enable arrives
   a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BUSY && card_busy && !ck_en) |=> (st == S_BUSY));

endmodule

// File: rtl/dpath_timer.sv
module dpath_timer #(
   parameter int unsigned LEN_W  = 32,
   parameter int unsigned DTMO_W = 32,
   parameter int unsigned ATMO_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [DTMO_W-1:0] cfg_dtmo,
   input  logic [ATMO_W-1:0] cfg_atmo,
   input  logic              ck_en,
   input  logic              start,
   input  logic              dir_rx,
   input  logic              byte_done,
   input  logic              ack_rx,
   input  logic              card_busy,
   output logic [2:0]        state,
   output logic [LEN_W-1:0]  count_left,
   output logic              data_end,
   output logic              data_tmo,
   output logic              ack_tmo
);

   import dpc_pkg::*;

   generate
      if (LEN_W < 1 || DTMO_W < 1 || ATMO_W < 1) begin : g_bad_cfg
         $error("dpath_timer: all widths must be at least 1");
      end
   endgenerate

   dp_state_e         st;
   logic              len_load, len_dec, len_zero;
   logic              dt_load, dt_dec, dt_zero;
   logic              at_load, at_dec, at_zero;
   logic [DTMO_W-1:0] dt_cnt;
   logic [ATMO_W-1:0] at_cnt;

   dpc_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dir_rx    (dir_rx),
      .byte_done (byte_done),
      .ack_rx    (ack_rx),
      .card_busy (card_busy),
      .ck_en     (ck_en),
      .len_zero  (len_zero),
      .dt_zero   (dt_zero),
      .at_zero   (at_zero),
      .st        (st),
      .len_load  (len_load),
      .len_dec   (len_dec),
      .dt_load   (dt_load),
      .dt_dec    (dt_dec),
      .at_load   (at_load),
      .at_dec    (at_dec),
      .data_end  (data_end),
      .data_tmo  (data_tmo),
      .ack_tmo   (ack_tmo)
   );

   dpc_downcnt #(.W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (len_load),
      .load_val (cfg_len),
      .dec      (len_dec),
      .cnt      (count_left),
      .zero     (len_zero)
   );

   dpc_downcnt #(.W(DTMO_W)) u_dtmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dt_load),
      .load_val (cfg_dtmo),
      .dec      (dt_dec),
      .cnt      (dt_cnt),
      .zero     (dt_zero)
   );

   dpc_downcnt #(.W(ATMO_W)) u_atmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (at_load),
      .load_val (cfg_atmo),
      .dec      (at_dec),
      .cnt      (at_cnt),
      .zero     (at_zero)
   );

   assign state = st;

   // R8: a clean finish never coincides with a timeout
   a_r8_end_clean: assert property (@(posedge clk) disable iff (!rst_n)
      data_end |-> (!data_tmo && !ack_tmo));

endmodule

// File: tb/sim_dpath_timer.sv
module sim_dpath_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_len = '0, cfg_dtmo = '0, cfg_atmo = '0;
   logic        ck_en = 0, start = 0, dir_rx = 0, byte_done = 0, ack_rx = 0, card_busy = 0;
   logic [2:0]  state;
   logic [31:0] count_left;
   logic        data_end, data_tmo, ack_tmo;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   dpath_timer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_dtmo(cfg_dtmo),
      .cfg_atmo(cfg_atmo), .ck_en(ck_en), .start(start), .dir_rx(dir_rx),
      .byte_done(byte_done), .ack_rx(ack_rx), .card_busy(card_busy),
      .state(state), .count_left(count_left), .data_end(data_end),
      .data_tmo(data_tmo), .ack_tmo(ack_tmo)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic flags(input string tag, input logic e, input logic d, input logic a);
      check({tag, " data_end"}, {31'd0, data_end}, {31'd0, e});
      check({tag, " data_tmo"}, {31'd0, data_tmo}, {31'd0, d});
      check({tag, " ack_tmo"},  {31'd0, ack_tmo},  {31'd0, a});
   endtask

   task automatic begin_xfer(input logic rx, input int len, input int dt, input int at);
      cfg_len = len; cfg_dtmo = dt; cfg_atmo = at;
      dir_rx = rx; start = 1'b1;
      tick();
      start = 1'b0;
      check("R2 state after start", {29'd0, state}, rx ? 32'd2 : 32'd1);
      check("R2 count loaded", count_left, len);
   endtask

   task automatic rx_run(input int len);
      ck_en = 0;
      begin_xfer(1'b1, len, 1000, 1000);
      for (int i = 1; i <= len; i++) begin
         byte_done = 1; tick(); byte_done = 0;
         check("R3 count step", count_left, len - i);
         flags("R4 no early end", 1'b0, 1'b0, 1'b0);
      end
      tick();
      check("R4 back to idle", {29'd0, state}, 32'd0);
      flags("R4 end pulse", 1'b1, 1'b0, 1'b0);
      tick();
      flags("R9 pulse one cycle", 1'b0, 1'b0, 1'b0);
   endtask

   task automatic tx_run(input int len);
      ck_en = 0;
      begin_xfer(1'b0, len, 1000, 1000);
      for (int i = 1; i <= len; i++) begin
         byte_done = 1; tick(); byte_done = 0;
         check("R3 tx count step", count_left, len - i);
      end
      tick();
      check("R5 wait ack", {29'd0, state}, 32'd3);
      card_busy = 1; ack_rx = 1; tick(); ack_rx = 0;
      check("R5 busy", {29'd0, state}, 32'd4);
      tick();
      check("R5 busy held", {29'd0, state}, 32'd4);
      flags("R5 no early end", 1'b0, 1'b0, 1'b0);
      card_busy = 0; tick();
      check("R5 idle after busy", {29'd0, state}, 32'd0);
      flags("R5 end pulse", 1'b1, 1'b0, 1'b0);
      tick();
   endtask

   task automatic dto_run(input int p, input bit gap);
      ck_en = 0;
      begin_xfer(1'b1, 10, p, 1000);
      for (int e = 1; e <= p + 1; e++) begin
         ck_en = 1; tick(); ck_en = 0;
         if (e <= p) begin
            check("R6 still waiting", {29'd0, state}, 32'd2);
            flags("R6 no early timeout", 1'b0, 1'b0, 1'b0);
            if (gap) begin
               tick();
               check("R6 hold without enable", {29'd0, state}, 32'd2);
               flags("R6 gated", 1'b0, 1'b0, 1'b0);
            end
         end else begin
            check("R6 idle on timeout", {29'd0, state}, 32'd0);
            flags("R6 timeout pulse", 1'b0, 1'b1, 1'b0);
         end
      end
      tick();
      flags("R9 timeout one cycle", 1'b0, 1'b0, 1'b0);
   endtask

   task automatic reach_wack(input int dt, input int at, input bit en);
      ck_en = en;
      begin_xfer(1'b0, 0, dt, at);
      tick();
      check("R5 wait ack reached", {29'd0, state}, 32'd3);
      flags("R6 no data timeout in send", 1'b0, 1'b0, 1'b0);
   endtask

   task automatic ato_run(input int a);
      reach_wack(1000, a, 1'b0);
      for (int e = 1; e <= a + 1; e++) begin
         ck_en = 1; tick(); ck_en = 0;
         if (e <= a) begin
            check("R7 still wait ack", {29'd0, state}, 32'd3);
            flags("R7 no early timeout", 1'b0, 1'b0, 1'b0);
         end else begin
            check("R7 idle on timeout", {29'd0, state}, 32'd0);
            flags("R7 timeout pulse", 1'b0, 1'b0, 1'b1);
         end
      end
      tick();
   endtask

   task automatic bto_run(input int p);
      reach_wack(p, 1000, 1'b1);
      card_busy = 1; ack_rx = 1; tick(); ack_rx = 0;
      check("R5 busy entered", {29'd0, state}, 32'd4);
      for (int e = 1; e <= p + 1; e++) begin
         tick();
         if (e <= p) begin
            check("R6 busy wait", {29'd0, state}, 32'd4);
         end else begin
            check("R6 busy timeout idle", {29'd0, state}, 32'd0);
            flags("R6 busy timeout pulse", 1'b0, 1'b1, 1'b0);
         end
      end
      ck_en = 0; card_busy = 0;
      tick();
   endtask

   initial begin
      #1;
      check("R1 reset state", {29'd0, state}, 32'd0);
      check("R1 reset count", count_left, 32'd0);
      flags("R1 reset pulses", 1'b0, 1'b0, 1'b0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      check("R1 state after reset", {29'd0, state}, 32'd0);
      flags("R1 pulses after reset", 1'b0, 1'b0, 1'b0);

      for (int l = 0; l <= 6; l++) rx_run(l);
      for (int l = 0; l <= 4; l++) tx_run(l);
      for (int p = 0; p <= 5; p++) dto_run(p, 1'b0);
      for (int p = 0; p <= 3; p++) dto_run(p, 1'b1);

      // R3: byte strobes in Idle leave the count (10 after timeout) untouched
      byte_done = 1; tick(); tick(); byte_done = 0;
      check("R3 byte ignored in idle", count_left, 32'd10);

      // R2: start ignored mid transfer
      ck_en = 0;
      begin_xfer(1'b1, 4, 1000, 1000);
      byte_done = 1; tick(); byte_done = 0;
      cfg_len = 99; dir_rx = 0; start = 1; tick(); start = 0;
      check("R2 start ignored state", {29'd0, state}, 32'd2);
      check("R2 start ignored count", count_left, 32'd3);
      repeat (3) begin byte_done = 1; tick(); byte_done = 0; end
      tick();
      flags("R4 end after ignored start", 1'b1, 1'b0, 1'b0);
      tick();

      for (int a = 0; a <= 4; a++) ato_run(a);
      for (int p = 0; p <= 4; p++) bto_run(p);

      // R8: zero length and zero data period expire on the same edge
      ck_en = 1;
      begin_xfer(1'b1, 0, 0, 1000);
      tick();
      check("R8 rx timeout wins state", {29'd0, state}, 32'd0);
      flags("R8 rx timeout wins", 1'b0, 1'b1, 1'b0);
      tick();
      // R8: ack and ack timeout on the same edge
      reach_wack(1000, 0, 1'b0);
      ck_en = 1; ack_rx = 1; card_busy = 1; tick(); ack_rx = 0; ck_en = 0;
      check("R8 ack timeout wins state", {29'd0, state}, 32'd0);
      flags("R8 ack timeout wins", 1'b0, 1'b0, 1'b1);
      tick();
      // R8: busy release and data timeout on the same edge
      reach_wack(0, 1000, 1'b0);
      ack_rx = 1; tick(); ack_rx = 0;
      card_busy = 0; ck_en = 1; tick(); ck_en = 0;
      check("R8 busy timeout wins state", {29'd0, state}, 32'd0);
      flags("R8 busy timeout wins", 1'b0, 1'b1, 1'b0);
      tick();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule